// File: doc/BRIEF.md
# Configurable interrupt output signaller

This block gathers per-source interrupt events into a pending register, masks it with a 32-bit enable register, and drives a single interrupt pin. A two-bit mode register sets how the pin signals. One bit picks the active sense of the pin. The other bit picks the signalling style: a steady level that follows the masked pending condition, or a fixed-width pulse that fires once each time that condition rises. Software clears pending bits with a write-one-to-clear strobe. The pending vector can be read directly.

Two resets are handled. The power-on reset returns everything to its default state. The bus reset only empties the pending register and silences the pin. The enable mask and both mode bits keep their programmed values across a bus reset. The pin is driven by a four-state machine:

- IDLE: pin inactive, no masked request.
- LEVEL: pin active in level style.
- PULSE: pin active for a counted number of clocks.
- HOLD: pin inactive because the request is still high after a pulse, or because the style changed to pulsed while the pin was active.

The transitions are:

- IDLE→LEVEL: request seen in level style.
- IDLE→PULSE: request seen in pulsed style.
- LEVEL→IDLE: request gone.
- LEVEL→HOLD: style switched to pulsed.
- PULSE→IDLE: pulse count done and request low.
- PULSE→HOLD: pulse count done and request still high.
- HOLD→IDLE: request gone.
- HOLD→LEVEL: style switched to level.
- Any state→IDLE: bus reset.

Top module: `irq_signaller`

## Requirements
- R1: After power-on reset the enable mask is all zero, the style is level, the polarity is active-low, pending is zero and the pin is high (inactive). An event then leaves the pin high, because no source is enabled.
- R2: An event strobe on bit i sets pending[i] at the next clock edge. A clear strobe bit i (write-one-to-clear) clears pending[i]. When event and clear hit the same bit in the same cycle, the event wins.
- R3: en_we loads en_wdata into the enable mask. A pending bit of a disabled source stays pending and does not move the pin. Once its enable is written, the pin asserts on the second edge after the write.
- R4: mode_we loads mode_wdata. Bit 0 is the polarity (1 = active high, 0 = active low) and bit 1 is the style (1 = pulsed, 0 = level).
- R5: In level style the pin goes active on the second edge after an enabled event. It stays active while any enabled pending bit is set, and goes inactive on the second edge after the last one is cleared.
- R6: In pulsed style, a rising masked-pending condition makes the pin active from the second edge after the event for exactly PULSE_CYCLES clocks (default 8, about 166 ns at 48 MHz).
- R7: In pulsed style, events that arrive during a pulse are merged into it. If the condition is still high when the pulse ends, the pin stays inactive until the condition has fallen and risen again. The pin is always inactive for at least one clock between pulses.
- R8: The polarity bit acts on the pin from the edge it is written: an inactive pin reads as the inverse of the polarity bit.
- R9: A bus reset clears all pending bits and makes the pin inactive at that edge. It leaves the enable mask, the style and the polarity unchanged.
- R10: Switching from level to pulsed while the pin is active makes the pin inactive, with no pulse. Switching from pulsed to level while the condition is high makes the pin active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_rst | input | 1 | Bus reset, synchronous, clears pending only |
| evt_i | input | NUM_SRC | Per-source event strobes |
| clr_i | input | NUM_SRC | Write-one-to-clear strobes for pending bits |
| en_we | input | 1 | Enable mask write strobe |
| en_wdata | input | NUM_SRC | Enable mask write data |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode data: bit 1 style, bit 0 polarity |
| irq_pin | output | 1 | Interrupt pin |
| pending_o | output | NUM_SRC | Pending status |

## Verification
The assertions check, on every cycle:

- a pending bit is only lost through a clear strobe or a bus reset;
- each event lands in pending;
- the state machine enters LEVEL or PULSE as soon as its request and style call for it;
- a pulse never outlasts its count and is never followed directly by another.

Only the bench's scenarios can show the end-to-end behaviour at the pin:

- the exact pulse width and the gap before the next pulse;
- the merging of events inside a pulse;
- the polarity seen at the pin;
- the enables and mode bits kept across a bus reset.

// File: rtl/irq_sig_pkg.sv
package irq_sig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEVEL,
        ST_PULSE,
        ST_HOLD
    } sig_state_e;

    typedef struct packed {
        logic pulsed;
        logic act_high;
    } sig_mode_t;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[i] <= 1'b0;
            end else if (bus_rst) begin
                pend_o[i] <= 1'b0;
            end else if (evt_i[i]) begin
                pend_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                pend_o[i] <= 1'b0;
            end
        end
    end

    // R2: a pending bit only drops through its clear strobe or a bus reset
    a_r2_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst |=> (($past(pend_o) & ~$past(clr_i) & ~pend_o) == '0));

    // R2: every event is recorded, even against a same-cycle clear
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst |=> (($past(evt_i) & ~pend_o) == '0));

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irq_sig_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic               mode_we,
    input  logic [1:0]         mode_wdata,
    output logic [NUM_SRC-1:0] en_o,
    output sig_mode_t          mode_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (en_we) begin
            en_o <= en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= '{pulsed: 1'b0, act_high: 1'b0};
        end else if (mode_we) begin
            mode_o <= sig_mode_t'(mode_wdata);
        end
    end

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_sig_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_rst,
    input  logic      req_i,
    input  sig_mode_t mode_i,
    output logic      pin_o
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);

    sig_state_e    state, state_nx;
    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_PULSE && !bus_rst) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    always_comb begin
        state_nx = state;
        if (bus_rst) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (req_i) state_nx = mode_i.pulsed ? ST_PULSE : ST_LEVEL;
                ST_LEVEL: if (!req_i) state_nx = ST_IDLE;
                          else if (mode_i.pulsed) state_nx = ST_HOLD;
                ST_PULSE: if (cnt == LAST) state_nx = req_i ? ST_HOLD : ST_IDLE;
                ST_HOLD:  if (!req_i) state_nx = ST_IDLE;
                          else if (!mode_i.pulsed) state_nx = ST_LEVEL;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_LEVEL, ST_PULSE: active = 1'b1;
            ST_IDLE, ST_HOLD:   active = 1'b0;
        endcase
        pin_o = mode_i.act_high ? active : !active;
    end

    // R5: level style with a live request always lands in LEVEL
    a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PULSE && !mode_i.pulsed && req_i && !bus_rst) |=> state == ST_LEVEL);

    // R6: a request from IDLE in pulsed style starts a fresh pulse
    a_r6_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mode_i.pulsed && req_i && !bus_rst)
        |=> (state == ST_PULSE && cnt == '0));

    // R6: the pulse count never passes its last value
    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> (cnt <= LAST));

    // R7: a finished pulse is followed by an inactive cycle
    a_r7_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && cnt == LAST) |=> (state == ST_IDLE || state == ST_HOLD));

    // R9: bus reset always returns the machine to IDLE
    a_r9_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> state == ST_IDLE);

endmodule

// File: rtl/irq_signaller.sv
module irq_signaller
    import irq_sig_pkg::*;
#(
    parameter int NUM_SRC      = 32,
    parameter int PULSE_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic               mode_we,
    input  logic [1:0]         mode_wdata,
    output logic               irq_pin,
    output logic [NUM_SRC-1:0] pending_o
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] en;
    sig_mode_t          mode;
    logic               req;

    irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_rst (bus_rst),
        .evt_i   (evt_i),
        .clr_i   (clr_i),
        .pend_o  (pend)
    );

    irq_cfg_bank #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .en_o       (en),
        .mode_o     (mode)
    );

    assign req = |(pend & en);

    irq_pin_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_rst (bus_rst),
        .req_i   (req),
        .mode_i  (mode),
        .pin_o   (irq_pin)
    );

    assign pending_o = pend;

    // R3: a masked-off pending bit alone never drives the request
    a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |-> !req);

endmodule

// File: tb/irq_signaller_bench.sv
module irq_signaller_bench;

    localparam int N  = 32;
    localparam int PW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_rst = 1'b0;
    logic [N-1:0] evt = '0;
    logic [N-1:0] clr = '0;
    logic         en_we = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic         mode_we = 1'b0;
    logic [1:0]   mode_wdata = '0;
    logic         irq_pin;
    logic [N-1:0] pending;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    irq_signaller #(.NUM_SRC(N), .PULSE_CYCLES(PW)) u_irq_signaller (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_rst),
        .evt_i      (evt),
        .clr_i      (clr),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .irq_pin    (irq_pin),
        .pending_o  (pending)
    );

    always #10 clk = ~clk;

    function automatic logic pin_level(input logic active, input logic act_high);
        return act_high ? active : !active;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        evt = '0; clr = '0; en_we = 1'b0; mode_we = 1'b0; bus_rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [N-1:0] m_pend, m_en, e, c;
        logic m_pol, old_req, exp_act;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 pin after reset", 32'(irq_pin), 32'd1);
        check("R1 pending after reset", pending, '0);
        evt[0] = 1'b1; step(); step();
        check("R1 pin with no enables", 32'(irq_pin), 32'd1);
        check("R2 event sets pending", pending, 32'h1);

        // R2: set wins over clear on the same bit; plain clear works
        evt[0] = 1'b1; clr[0] = 1'b1; step();
        check("R2 set wins", pending, 32'h1);
        clr[0] = 1'b1; step();
        check("R2 clear", pending, '0);

        // R3: disabled pending stays, enabling later asserts pin (level, active low)
        evt[9] = 1'b1; step(); step(); step();
        check("R3 pending kept while masked", pending, 32'h200);
        check("R3 pin idle while masked", 32'(irq_pin), 32'd1);
        en_we = 1'b1; en_wdata = 32'h208; step();
        check("R3 pin one edge after enable", 32'(irq_pin), 32'd1);
        step();
        check("R3 pin active after enable", 32'(irq_pin), 32'd0);

        // R8/R4: polarity flip acts at once
        mode_we = 1'b1; mode_wdata = 2'b01; step();
        check("R8 active high now", 32'(irq_pin), 32'd1);

        // R5: clear last enabled bit -> inactive two edges later
        clr = 32'h200; step();
        check("R5 still active one edge after clear", 32'(irq_pin), 32'd1);
        step();
        check("R5 inactive after clear", 32'(irq_pin), 32'd0);

        // R9: bus reset keeps config
        evt[3] = 1'b1; step(); step();
        check("R5 active on enabled event", 32'(irq_pin), 32'd1);
        bus_rst = 1'b1; step();
        check("R9 pending cleared", pending, '0);
        check("R9 pin inactive", 32'(irq_pin), 32'd0);
        evt[9] = 1'b1; step(); step();
        check("R9 enable and mode kept", 32'(irq_pin), 32'd1);
        bus_rst = 1'b1; step();

        // R6/R7: pulsed style, active high
        mode_we = 1'b1; mode_wdata = 2'b11; step();
        evt[3] = 1'b1; step();
        check("R6 pin not yet active", 32'(irq_pin), 32'd0);
        for (int i = 1; i <= 11; i++) begin
            if (i == 3) evt[3] = 1'b1;
            step();
            check($sformatf("R6 pulse step %0d", i), 32'(irq_pin), 32'(i <= PW));
        end
        clr[3] = 1'b1; step();
        evt[3] = 1'b1; step();
        for (int i = 1; i <= 12; i++) begin
            if (i == 2) evt[3] = 1'b1;
            if (i == 5) clr[3] = 1'b1;
            if (i == 6) evt[3] = 1'b1;
            step();
            check($sformatf("R7 merged step %0d", i), 32'(irq_pin), 32'(i <= PW));
        end
        clr[3] = 1'b1; step();
        check("R7 gap", 32'(irq_pin), 32'd0);
        evt[3] = 1'b1; step(); step();
        check("R7 new pulse after fall", 32'(irq_pin), 32'd1);
        repeat (PW) step();
        check("R7 held low, request high", 32'(irq_pin), 32'd0);

        // R10: pulsed -> level with request high, then back
        mode_we = 1'b1; mode_wdata = 2'b01; step();
        check("R10 still hold one edge", 32'(irq_pin), 32'd0);
        step();
        check("R10 level active", 32'(irq_pin), 32'd1);
        mode_we = 1'b1; mode_wdata = 2'b11; step();
        check("R10 active one edge", 32'(irq_pin), 32'd1);
        step(); step();
        check("R10 no pulse after switch", 32'(irq_pin), 32'd0);

        // R2/R3/R4/R5/R8/R9: random level-style traffic against a model
        mode_we = 1'b1; mode_wdata = 2'b00; bus_rst = 1'b1; step();
        m_pend = '0; m_en = 32'h208; m_pol = 1'b0;
        for (int k = 0; k < 600; k++) begin
            e = $urandom & $urandom & $urandom;
            c = $urandom & $urandom;
            evt = e; clr = c;
            old_req = |(m_pend & m_en);
            if ($urandom_range(7) == 0) begin
                en_we = 1'b1; en_wdata = $urandom & $urandom;
            end
            if ($urandom_range(7) == 0) begin
                mode_we = 1'b1; mode_wdata = {1'b0, 1'($urandom_range(1))};
            end
            if ($urandom_range(31) == 0) bus_rst = 1'b1;
            if (bus_rst) begin
                m_pend = '0; exp_act = 1'b0;
            end else begin
                m_pend = (m_pend & ~c) | e; exp_act = old_req;
            end
            if (en_we) m_en = en_wdata;
            if (mode_we) m_pol = mode_wdata[0];
            step();
            check("R2 random pending", pending, m_pend);
            check("R5 random pin", 32'(irq_pin), 32'(pin_level(exp_act, m_pol)));
        end

        finish_run();
    end

endmodule